// File: doc/BRIEF.md
# Tiled Display Host Port

This block connects an 8-bit parallel microcontroller bus to the display memory of one driver core. Several identical cores can be tiled into a 4x4 array to cover a larger panel. Each core is strapped with a 4-bit tile identity, and the host addresses a core by presenting the matching 4-bit tile select. Only the selected core answers. The others leave their state untouched.

A host write is either a command or a display byte, chosen by `cmd_n_data`. A display byte goes to the current column address, and that address then steps on by one. A short busy window follows each accepted display byte. During the window the port rejects further writes, but the host may still read the status byte.

In merge mode each display byte is combined with the stored byte. The port reads the stored byte, ORs the host byte into it and writes the result back. This happens in the background while the host is already free. The RAM port assumes a synchronous memory with one cycle of read latency.

Top module: `lcd_host_port`

## Requirements
- R1: A write or read is accepted only when `tile_sel` equals `cas_id`. Bits [1:0] of `cas_id` give the row position and bits [3:2] the column position. A non-matching access causes no RAM access, no change of column address or mode, and keeps `bus_oe` low.
- R2: A display byte (`cmd_n_data`=0) accepted at a clock edge with merge mode off drives `ram_we` high for exactly the following cycle. In that cycle `ram_addr` is the column address before the write and `ram_wdata` is the host byte.
- R3: `busy` is high for exactly HOLD (default 2) cycles after each accepted display byte. Writes presented while `busy` is high are ignored, whether command or data.
- R4: The column address increases by one after each accepted display byte and wraps from 63 to 0.
- R5: A command byte with bits [7:6]=00 loads the column address from bits [5:0]. It does not raise `busy`.
- R6: Command 0x40 turns merge mode on and command 0x41 turns it off. Other commands with bits [7:6] not 00 have no effect.
- R7: In merge mode, an accepted display byte drives `ram_re` high in the next cycle with `ram_addr` set to the target. In the cycle after that, `ram_we` is high at the same address and `ram_wdata` equals `ram_rdata` OR the host byte. `busy` still lasts HOLD cycles.
- R8: While `rd_en` is high and the tile matches, `bus_oe` is 1 and `bus_out` is {busy, merge mode, column address[5:0]}. This holds in the same cycle and also during busy. Otherwise `bus_oe` and `bus_out` are 0.
- R9: A high `rst` clears busy, column address and merge mode, and cancels any pending RAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| cas_id | input | 4 | Strapped tile identity: [1:0] row position, [3:2] column position |
| tile_sel | input | 4 | Tile addressed by the host |
| wr_en | input | 1 | Host write strobe, sampled on the rising edge |
| rd_en | input | 1 | Host status read strobe |
| cmd_n_data | input | 1 | 1 = command byte, 0 = display byte |
| bus_in | input | 8 | Host write data |
| bus_out | output | 8 | Status byte toward the host |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| busy | output | 1 | Write window closed |
| ram_we | output | 1 | Display RAM write enable |
| ram_re | output | 1 | Display RAM read enable (merge mode) |
| ram_addr | output | 6 | Display RAM column address |
| ram_wdata | output | 8 | Display RAM write data |
| ram_rdata | input | 8 | Display RAM read data, valid the cycle after `ram_re` |

## Verification
Two functions can fall in the same cycle: a status read during the busy window, and a new host write arriving while the previous one is still being stored. The second case is most visible in merge mode, where the read and write-back are still running. The bench provokes both by holding `wr_en` high across consecutive cycles with changing bytes, and by raising `rd_en` during the window. A cycle-level reference model built from the requirements then judges, every cycle, which writes were dropped, what the status byte shows and what reaches the RAM port. A final comparison of a bench-side RAM against the expected image covers all 64 addresses after plain and merged sweeps.

// File: rtl/lcd_host_port.sv
module lcd_host_port #(
  parameter int AW   = 6,
  parameter int HOLD = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    cas_id,
  input  logic [3:0]    tile_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          cmd_n_data,
  input  logic [7:0]    bus_in,
  output logic [7:0]    bus_out,
  output logic          bus_oe,
  output logic          busy,
  output logic          ram_we,
  output logic          ram_re,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata
);

  localparam int CW = $clog2(HOLD + 1);

  logic          hit, take, take_dat, take_cmd;
  logic [CW-1:0] cnt;
  logic [AW-1:0] col, wr_addr;
  logic [7:0]    wr_data;
  logic          rmw_mode, pend_we, rd_phase, mod_phase;

  assign hit      = (tile_sel == cas_id);
  assign take     = hit && wr_en && !busy;
  assign take_dat = take && !cmd_n_data;
  assign take_cmd = take && cmd_n_data;
  assign busy     = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (take_dat) cnt <= CW'(HOLD);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col      <= '0;
      rmw_mode <= 1'b0;
    end else if (take_dat) begin
      col <= col + 1'b1;
    end else if (take_cmd) begin
      if (bus_in[7:6] == 2'b00) col <= bus_in[AW-1:0];
      else if (bus_in == 8'h40) rmw_mode <= 1'b1;
      else if (bus_in == 8'h41) rmw_mode <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_we   <= 1'b0;
      rd_phase  <= 1'b0;
      mod_phase <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      pend_we   <= take_dat && !rmw_mode;
      rd_phase  <= take_dat && rmw_mode;
      mod_phase <= rd_phase;
      if (take_dat) begin
        wr_addr <= col;
        wr_data <= bus_in;
      end
    end
  end

  assign ram_addr  = wr_addr;
  assign ram_re    = rd_phase;
  assign ram_we    = pend_we || mod_phase;
  assign ram_wdata = mod_phase ? (ram_rdata | wr_data) : wr_data;

  assign bus_oe  = hit && rd_en;
  assign bus_out = bus_oe ? {busy, rmw_mode, 6'(col)} : 8'h00;

  // R3
  busy_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && wr_en && !cmd_n_data && !busy) |=> busy);

  // R3
  busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(col) && $stable(rmw_mode)));

  // R1
  foreign_tile_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(col) && $stable(rmw_mode) && !ram_re));

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && wr_en && !cmd_n_data && !busy) |=> (col == $past(col) + 1'b1));

  // R7
  merge_order_chk: assert property (@(posedge clk) disable iff (rst)
    ram_re |=> (ram_we && $stable(ram_addr)));

  // R7
  ram_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, ram_re}));

  // R2
  we_source_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !$past(ram_re)) |-> $past(hit && wr_en && !cmd_n_data));

endmodule

// File: tb/tb_lcd_host_port.sv
module tb_lcd_host_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] MYID = 4'b0110;

  logic clk = 0, rst = 1;
  logic [3:0] tile_sel = MYID;
  logic wr_en = 0, rd_en = 0, cmd_n_data = 0;
  logic [7:0] bus_in = 0, bus_out, ram_wdata;
  logic [7:0] ram_rdata = 0;
  logic bus_oe, busy, ram_we, ram_re;
  logic [5:0] ram_addr;

  int total = 0, bad = 0;
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_host_port dut (
    .clk(clk), .rst(rst), .cas_id(MYID), .tile_sel(tile_sel),
    .wr_en(wr_en), .rd_en(rd_en), .cmd_n_data(cmd_n_data), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .busy(busy), .ram_we(ram_we),
    .ram_re(ram_re), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  // reference model built from the requirements
  int m_cnt = 0;
  logic [5:0] m_col = 0, m_addr = 0;
  logic [7:0] m_dat = 0;
  logic m_rmw = 0, m_we = 0, m_re = 0, m_mod = 0, acc;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_col <= 0; m_rmw <= 0; m_we <= 0; m_re <= 0; m_mod <= 0;
    end else begin
      acc = (tile_sel == MYID) && wr_en && (m_cnt == 0);
      if (m_we) exp_mem[m_addr] <= m_dat;
      if (m_mod) exp_mem[m_addr] <= exp_mem[m_addr] | m_dat;
      m_we  <= acc && !cmd_n_data && !m_rmw;
      m_re  <= acc && !cmd_n_data && m_rmw;
      m_mod <= m_re;
      if (acc && !cmd_n_data) begin
        m_addr <= m_col; m_dat <= bus_in; m_col <= m_col + 6'd1; m_cnt <= 2;
      end else if (m_cnt > 0) m_cnt <= m_cnt - 1;
      if (acc && cmd_n_data) begin
        if (bus_in[7:6] == 2'b00) m_col <= bus_in[5:0];
        else if (bus_in == 8'h40) m_rmw <= 1'b1;
        else if (bus_in == 8'h41) m_rmw <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (started && !rst) begin
      chk(busy == (m_cnt != 0), "R3 busy", busy, m_cnt != 0);
      chk(ram_we == (m_we || m_mod), "R2,R7 ram_we", ram_we, m_we || m_mod);
      chk(ram_re == m_re, "R7 ram_re", ram_re, m_re);
      if (ram_we || ram_re) chk(ram_addr == m_addr, "R2,R4 ram_addr", ram_addr, m_addr);
      if (m_we) chk(ram_wdata == m_dat, "R2 wdata", ram_wdata, m_dat);
      if (m_mod) chk(ram_wdata == (exp_mem[m_addr] | m_dat), "R7 merged wdata",
                     ram_wdata, exp_mem[m_addr] | m_dat);
      chk(bus_oe == (rd_en && tile_sel == MYID), "R1,R8 bus_oe", bus_oe,
          rd_en && tile_sel == MYID);
      if (rd_en && tile_sel == MYID)
        chk(bus_out == {m_cnt != 0, m_rmw, m_col}, "R4,R5,R6,R8 status",
            bus_out, {m_cnt != 0, m_rmw, m_col});
      else chk(bus_out == 8'h00, "R1,R8 quiet bus", bus_out, 0);
    end
  end

  task automatic drive(input bit w, input bit r, input bit c, input logic [7:0] d,
                       input logic [3:0] s);
    @(negedge clk);
    wr_en = w; rd_en = r; cmd_n_data = c; bus_in = d; tile_sel = s;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 8'h00, MYID);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = 0; exp_mem[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0; started = 1;
    drive(0, 1, 0, 0, MYID); #2;
    chk(bus_out == 8'h00 && !busy, "R9 reset status", bus_out, 0);
    // R1: tile select sweep
    for (int s = 0; s < 16; s++) begin
      drive(1, 1, 0, 8'hA0 + 8'(s), 4'(s));
      idle(3);
    end
    drive(0, 1, 0, 0, MYID); #2;
    chk(bus_out[5:0] == 6'd1, "R1 only own tile accepted", bus_out[5:0], 1);
    // R5, R4, R3: set address near end, back-to-back writes while busy
    drive(1, 0, 1, 8'h3E, MYID);
    for (int k = 0; k < 9; k++) drive(1, 1, 0, 8'h10 + 8'(k), MYID);
    idle(3);
    drive(0, 1, 0, 0, MYID); #2;
    chk(bus_out[5:0] == 6'd1, "R4 wrap 63 to 0", bus_out[5:0], 1);
    // R6: ignored commands, then merge mode
    drive(1, 0, 1, 8'h80, MYID); drive(1, 0, 1, 8'hC3, MYID);
    drive(0, 1, 0, 0, MYID); #2;
    chk(bus_out[6] == 1'b0, "R6 other command ignored", bus_out[6], 0);
    drive(1, 0, 1, 8'h40, MYID);
    drive(0, 1, 0, 0, MYID); #2;
    chk(bus_out[6] == 1'b1, "R6 merge on", bus_out[6], 1);
    drive(1, 0, 1, 8'h3E, MYID);
    for (int k = 0; k < 9; k++) drive(1, 1, 0, 8'h01 << (k % 8), MYID);
    idle(3);
    drive(1, 0, 1, 8'h41, MYID);
    // plain sweep over every address
    drive(1, 0, 1, 8'h00, MYID);
    for (int a = 0; a < 64; a++) begin drive(1, 0, 0, 8'(a * 7 + 3), MYID); idle(2); end
    // merged sweep, writes held high to collide with busy
    drive(1, 0, 1, 8'h40, MYID);
    drive(1, 0, 1, 8'h05, MYID);
    for (int a = 0; a < 120; a++) drive(1, a[0], 0, 8'h81 ^ 8'(a), MYID);
    idle(2);
    // R9: reset during busy
    drive(1, 0, 0, 8'h55, MYID);
    @(negedge clk); rst = 1; wr_en = 0;
    @(negedge clk); rst = 0;
    rd_en = 1; #2;
    chk(bus_out == 8'h00 && !busy && !ram_we && !ram_re, "R9 mid reset", bus_out, 0);
    idle(3);
    for (int a = 0; a < 64; a++)
      chk(mem[a] == exp_mem[a], "R2,R7 ram image", mem[a], exp_mem[a]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule